// File: doc/BRIEF.md
# ADC Scan-Mode Conversion Sequencer

This block sequences an external analog-to-digital converter through a small group of consecutive input channels. While its run bit is set it starts one conversion at a time, waits for the converter to report completion, stores the returned 10-bit value in a register that belongs to that channel, and moves on to the next channel. After the last channel of the group it raises an end-of-scan flag and wraps back to the group's first channel. The scan repeats until the run bit is cleared.

Software writes one configuration word. It holds the run bit, a group bit that picks the first channel, a two-bit field that picks how many channels are scanned, and an interrupt enable. A separate pulse clears the flag, and an external trigger pulse can also set the run bit. Stored results are read back through a combinational read port addressed by channel number. The converter is outside the block. It receives a one-cycle start pulse together with a channel number, and some cycles later it answers with a one-cycle done pulse and its result.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the run bit, the end-of-scan flag and the interrupt request are 0, no start pulse is issued, and every data register reads 0.
- R2: A configuration write with the run bit 1, or a one-cycle pulse on the external trigger, sets the run bit. The first start pulse appears two cycles after the write or trigger cycle.
- R3: The first channel is 2 when the group bit is 0 and 4 when it is 1. Later channels of a pass follow in ascending order.
- R4: The count field selects the number of channels per pass: 00 gives one, 01 gives two, 10 gives three, and 11 is treated as three.
- R5: While running, the next start pulse is issued in the cycle right after the done pulse that finished the previous channel.
- R6: A result returned while running is stored in the data register of the channel being converted, and the read port returns it when that channel number is applied.
- R7: When the last channel of a pass finishes, the end-of-scan flag is set and the next start pulse addresses the group's first channel.
- R8: The interrupt request is high exactly when the end-of-scan flag and the interrupt enable are both 1.
- R9: The end-of-scan flag stays set until a flag-clear pulse is given. If a pass completes in the same cycle, setting takes priority over clearing.
- R10: Clearing the run bit stops the scan, so no further start pulse is issued. A later restart always begins at the group's first channel.
- R11: A done pulse that arrives after the run bit was cleared in the middle of a conversion is ignored, and no data register changes.
- R12: Group and count values written in the same cycle as the run bit is set apply to the scan that this write starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load the configuration fields below |
| cfg_run | input | 1 | Run bit value to write |
| cfg_group | input | 1 | Group select: 0 starts at channel 2, 1 starts at channel 4 |
| cfg_count | input | 2 | Channel count select |
| cfg_irq_en | input | 1 | Interrupt enable value to write |
| flag_clr | input | 1 | Clears the end-of-scan flag |
| ext_trig | input | 1 | External trigger pulse that sets the run bit |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_chan | output | 3 | Channel to convert, valid with conv_start |
| conv_done | input | 1 | One-cycle completion pulse from the converter |
| conv_result | input | 10 | Conversion result, valid with conv_done |
| rd_chan | input | 3 | Channel number for the read port |
| rd_data | output | 10 | Stored result of channel rd_chan |
| scan_run | output | 1 | Current run bit |
| eos_flag | output | 1 | End-of-scan flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a stop that lands inside a conversion, where the converter's late done pulse must leave every register untouched. The bench's converter model exposes its countdown. The stop task waits until at least two cycles of that countdown remain before it writes the run bit low, so the done pulse reliably arrives after the sequencer has gone idle. It then reads back the aborted channel's register. Restarts with a new group and count in the same write, and a restart through the external trigger, check that each scan begins at its first channel.

// File: rtl/adc_scan_pkg.sv
// Package: shared widths, channel constants and the sequencer state type.
// Assumes at most 8 channel numbers, so channel ids fit in 3 bits.
package adc_scan_pkg;
    parameter int CH_W    = 3;
    parameter int RES_W   = 10;
    parameter int NUM_CH  = 1 << CH_W;
    parameter logic [CH_W-1:0] GRP0_FIRST = 3'd2;
    parameter logic [CH_W-1:0] GRP1_FIRST = 3'd4;

    typedef enum logic {ST_IDLE, ST_BUSY} seq_state_t;

    // Number of channels per pass minus one; code 11 behaves like 10.
    function automatic logic [CH_W-1:0] span_minus1(input logic [1:0] code);
        return (code == 2'b11) ? 3'd2 : {1'b0, code};
    endfunction
endpackage

// File: rtl/adc_scan_cfg.sv
// Module: configuration and status registers of the sequencer.
// Holds run bit, group, count, interrupt enable and end-of-scan flag.
// Assumes pass_done is a single-cycle pulse from the stepping logic.
module adc_scan_cfg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic       cfg_run,
    input  logic       cfg_group,
    input  logic [1:0] cfg_count,
    input  logic       cfg_irq_en,
    input  logic       flag_clr,
    input  logic       ext_trig,
    input  logic       pass_done,
    output logic       run_q,
    output logic       group_q,
    output logic [1:0] count_q,
    output logic       irq_en_q,
    output logic       flag_q
);
    // Load software fields; a trigger pulse only sets the run bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            group_q  <= 1'b0;
            count_q  <= 2'b00;
            irq_en_q <= 1'b0;
        end else if (cfg_we) begin
            run_q    <= cfg_run;
            group_q  <= cfg_group;
            count_q  <= cfg_count;
            irq_en_q <= cfg_irq_en;
        end else if (ext_trig) begin
            run_q    <= 1'b1;
        end
    end

    // End-of-scan flag: a completed pass wins over a clear request.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (pass_done) flag_q <= 1'b1;
        else if (flag_clr)  flag_q <= 1'b0;
    end
endmodule

// File: rtl/adc_scan_fsm.sv
// Module: channel stepping logic driving the converter handshake.
// Latches first and last channel when a scan starts, issues a registered
// start pulse, and steps (wrapping) on each done seen while running.
// Assumes the converter answers each start with exactly one done pulse.
module adc_scan_fsm
    import adc_scan_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_q,
    input  logic            group_q,
    input  logic [1:0]      count_q,
    input  logic            conv_done,
    output logic            conv_start,
    output logic [CH_W-1:0] conv_chan,
    output logic            wr_en,
    output logic [CH_W-1:0] wr_chan,
    output logic            pass_done,
    output logic            busy
);
    seq_state_t      state;
    logic [CH_W-1:0] cur_chan;
    logic [CH_W-1:0] first_chan;
    logic [CH_W-1:0] last_chan;
    logic            start_q;
    logic [CH_W-1:0] sel_first;

    // Starting channel chosen by the group bit.
    always_comb sel_first = group_q ? GRP1_FIRST : GRP0_FIRST;

    // Step through the group while the run bit stays set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cur_chan   <= '0;
            first_chan <= '0;
            last_chan  <= '0;
            start_q    <= 1'b0;
        end else begin
            start_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (run_q) begin
                        first_chan <= sel_first;
                        last_chan  <= sel_first + span_minus1(count_q);
                        cur_chan   <= sel_first;
                        start_q    <= 1'b1;
                        state      <= ST_BUSY;
                    end
                end
                default: begin
                    if (!run_q) begin
                        state <= ST_IDLE;
                    end else if (conv_done) begin
                        start_q  <= 1'b1;
                        cur_chan <= (cur_chan == last_chan) ? first_chan
                                                            : cur_chan + 1'b1;
                    end
                end
            endcase
        end
    end

    // Accept a result only while busy and still running.
    always_comb begin
        busy       = (state == ST_BUSY);
        wr_en      = busy && run_q && conv_done;
        wr_chan    = cur_chan;
        pass_done  = wr_en && (cur_chan == last_chan);
        conv_start = start_q;
        conv_chan  = cur_chan;
    end
endmodule

// File: rtl/adc_scan_bank.sv
// Module: per-channel result registers with a combinational read port.
// One register per channel number; unused numbers simply stay at zero.
module adc_scan_bank #(
    parameter int CH_W  = 3,
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_chan,
    input  logic [RES_W-1:0] wr_data,
    input  logic [CH_W-1:0]  rd_chan,
    output logic [RES_W-1:0] rd_data
);
    localparam int NREG = 1 << CH_W;
    logic [RES_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Capture the result addressed to this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)                         regs[g] <= '0;
            else if (wr_en && wr_chan == CH_W'(g)) regs[g] <= wr_data;
        end
    end

    // Read port mux.
    always_comb rd_data = regs[rd_chan];
endmodule

// File: rtl/adc_scan_seq.sv
// Module: top of the scan sequencer; wires configuration, stepping logic
// and result bank. Assumes a single converter shared by all channels.
module adc_scan_seq
    import adc_scan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_run,
    input  logic             cfg_group,
    input  logic [1:0]       cfg_count,
    input  logic             cfg_irq_en,
    input  logic             flag_clr,
    input  logic             ext_trig,
    output logic             conv_start,
    output logic [CH_W-1:0]  conv_chan,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    input  logic [CH_W-1:0]  rd_chan,
    output logic [RES_W-1:0] rd_data,
    output logic             scan_run,
    output logic             eos_flag,
    output logic             irq
);
    logic            run_q, group_q, irq_en_q, flag_q;
    logic [1:0]      count_q;
    logic            wr_en, pass_done, busy;
    logic [CH_W-1:0] wr_chan;

    adc_scan_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_run(cfg_run),
        .cfg_group(cfg_group), .cfg_count(cfg_count), .cfg_irq_en(cfg_irq_en),
        .flag_clr(flag_clr), .ext_trig(ext_trig), .pass_done(pass_done),
        .run_q(run_q), .group_q(group_q), .count_q(count_q),
        .irq_en_q(irq_en_q), .flag_q(flag_q)
    );

    adc_scan_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .run_q(run_q), .group_q(group_q),
        .count_q(count_q), .conv_done(conv_done), .conv_start(conv_start),
        .conv_chan(conv_chan), .wr_en(wr_en), .wr_chan(wr_chan),
        .pass_done(pass_done), .busy(busy)
    );

    adc_scan_bank #(.CH_W(CH_W), .RES_W(RES_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
        .wr_data(conv_result), .rd_chan(rd_chan), .rd_data(rd_data)
    );

    // Status outputs.
    always_comb begin
        scan_run = run_q;
        eos_flag = flag_q;
        irq      = flag_q && irq_en_q;
    end
endmodule

// File: rtl/adc_scan_chk.sv
// Module: protocol checker for adc_scan_seq, attached by bind below.
module adc_scan_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       run_q,
    input logic       busy,
    input logic       conv_start,
    input logic [2:0] conv_chan,
    input logic       conv_done,
    input logic       pass_done,
    input logic       flag_clr,
    input logic       eos_flag,
    input logic       irq
);
    a_r2_start_follows_run: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(run_q) && !busy) |=> conv_start);
    a_r3_chan_window: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (conv_chan >= 3'd2 && conv_chan <= 3'd6));
    a_r5_next_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_q && conv_done) |=> conv_start);
    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> eos_flag);
    a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (eos_flag && !flag_clr) |=> eos_flag);
    a_r9_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !pass_done) |=> !eos_flag);
    a_r10_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !$past(run_q)) |-> !conv_start);
endmodule

bind adc_scan_seq adc_scan_chk u_chk (
    .clk(clk), .rst_n(rst_n), .run_q(run_q), .busy(busy),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
    .pass_done(pass_done), .flag_clr(flag_clr), .eos_flag(eos_flag), .irq(irq)
);

// File: tb/sim_adc_scan_seq.sv
// Scoreboard bench: driver tasks queue expected channel order, the
// converter model/monitor pops and compares on each start pulse.
module sim_adc_scan_seq;
    localparam int LAT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0, cfg_run = 1'b0, cfg_group = 1'b0, cfg_irq_en = 1'b0;
    logic [1:0] cfg_count = 2'b00;
    logic       flag_clr = 1'b0, ext_trig = 1'b0;
    logic       conv_start;
    logic [2:0] conv_chan;
    logic       conv_done = 1'b0;
    logic [9:0] conv_result = '0;
    logic [2:0] rd_chan = 3'd0;
    logic [9:0] rd_data;
    logic       scan_run, eos_flag, irq;

    int total = 0, bad = 0;
    logic [2:0] exp_q[$];
    logic [9:0] exp_reg [8];
    int  cnt = 0, seq = 0, passes = 0, b_last = 0;
    logic [2:0] mchan = 3'd0;
    bit  b_run = 0, prev_done = 0, fin = 0;

    always #5 clk = ~clk;

    adc_scan_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_run(cfg_run),
        .cfg_group(cfg_group), .cfg_count(cfg_count), .cfg_irq_en(cfg_irq_en),
        .flag_clr(flag_clr), .ext_trig(ext_trig), .conv_start(conv_start),
        .conv_chan(conv_chan), .conv_done(conv_done), .conv_result(conv_result),
        .rd_chan(rd_chan), .rd_data(rd_data), .scan_run(scan_run),
        .eos_flag(eos_flag), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Converter model and monitor, acting on falling edges.
    always @(negedge clk) begin
        if (conv_done) conv_done = 1'b0;
        if (b_run && prev_done)
            chk(conv_start, "R5 start right after done", conv_start, 1);
        prev_done = 0;
        if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
                conv_result = 10'((seq * 37 + int'(mchan)) & 1023);
                seq++;
                conv_done = 1'b1;
                prev_done = 1;
                if (b_run) begin
                    exp_reg[mchan] = conv_result;
                    if (int'(mchan) == b_last) passes++;
                end
            end
        end
        if (conv_start) begin
            if (exp_q.size() == 0) begin
                chk(0, "R10 start with none expected", conv_chan, -1);
            end else begin
                logic [2:0] e;
                e = exp_q.pop_front();
                chk(conv_chan == e, "R3 R4 R7 channel order", conv_chan, e);
            end
            mchan = conv_chan;
            cnt = LAT;
        end
    end

    task automatic expect_scan(input bit grp, input logic [1:0] code);
        int first, n;
        first = grp ? 4 : 2;
        n = (code == 2'b11) ? 3 : int'(code) + 1;
        b_last = first + n - 1;
        exp_q.delete();
        for (int i = 0; i < 80; i++) exp_q.push_back(3'(first + (i % n)));
        b_run = 1;
    endtask

    task automatic wr_cfg(input bit run, input bit grp, input logic [1:0] code, input bit ien);
        @(negedge clk);
        cfg_we = 1; cfg_run = run; cfg_group = grp; cfg_count = code; cfg_irq_en = ien;
        if (run) expect_scan(grp, code);
        @(negedge clk);
        cfg_we = 0;
    endtask

    // Stop inside a conversion so its done arrives after the run bit fell.
    task automatic stop_scan(input bit grp, input logic [1:0] code, input bit ien);
        @(negedge clk);
        while (cnt < 2) @(negedge clk);
        cfg_we = 1; cfg_run = 0; cfg_group = grp; cfg_count = code; cfg_irq_en = ien;
        b_run = 0;
        exp_q.delete();
        @(negedge clk);
        cfg_we = 0;
        repeat (12) @(negedge clk);
        chk(scan_run == 0, "R10 run bit cleared", scan_run, 0);
        rd_chan = mchan;
        @(negedge clk);
        chk(rd_data == exp_reg[mchan], "R11 aborted result dropped", rd_data, exp_reg[mchan]);
    endtask

    task automatic check_regs(input int lo, input int hi);
        for (int c = lo; c <= hi; c++) begin
            rd_chan = 3'(c);
            @(negedge clk);
            chk(rd_data == exp_reg[c], "R6 stored result", rd_data, exp_reg[c]);
        end
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_clr = 1;
        @(negedge clk);
        flag_clr = 0;
        @(negedge clk);
        chk(eos_flag == 0, "R9 flag cleared", eos_flag, 0);
        chk(irq == 0, "R8 irq low without flag", irq, 0);
        passes = 0;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) exp_reg[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(scan_run == 0, "R1 run after reset", scan_run, 0);
        chk(eos_flag == 0 && irq == 0, "R1 flag/irq after reset", eos_flag, 0);
        chk(conv_start == 0, "R1 no start after reset", conv_start, 0);
        rd_chan = 3'd3;
        @(negedge clk);
        chk(rd_data == 0, "R1 data register after reset", rd_data, 0);

        // Group 0, three channels, interrupt enabled; start latency (R2)
        wr_cfg(1, 0, 2'b10, 1);
        chk(conv_start == 0, "R2 no start one cycle after write", conv_start, 0);
        @(negedge clk);
        chk(conv_start == 1 && conv_chan == 2, "R2 R3 first start", conv_chan, 2);
        repeat (60) @(negedge clk);
        stop_scan(0, 2'b10, 1);
        chk(eos_flag == (passes > 0), "R7 flag after passes", eos_flag, 1);
        chk(irq == 1, "R8 irq with enable", irq, 1);
        check_regs(2, 4);
        repeat (10) @(negedge clk);
        chk(eos_flag == 1, "R9 flag holds", eos_flag, 1);
        clear_flag();

        // New group and count in the same write as run (R12), single channel
        wr_cfg(1, 1, 2'b00, 0);
        repeat (40) @(negedge clk);
        stop_scan(1, 2'b00, 0);
        chk(eos_flag == 1, "R7 R12 flag single channel", eos_flag, 1);
        chk(irq == 0, "R8 irq masked", irq, 0);
        check_regs(4, 4);
        clear_flag();

        // Restart through external trigger, group 1 two channels (R2, R10)
        wr_cfg(0, 1, 2'b01, 1);
        @(negedge clk);
        ext_trig = 1;
        expect_scan(1, 2'b01);
        @(negedge clk);
        ext_trig = 0;
        chk(scan_run == 1, "R2 trigger sets run", scan_run, 1);
        repeat (50) @(negedge clk);
        stop_scan(1, 2'b01, 1);
        chk(irq == 1, "R8 irq after trigger scan", irq, 1);
        check_regs(4, 5);
        clear_flag();

        // Count code 11 acts as three channels (R4)
        wr_cfg(1, 0, 2'b11, 0);
        repeat (55) @(negedge clk);
        stop_scan(0, 2'b11, 0);
        check_regs(2, 4);
        chk(rd_data == exp_reg[4], "R4 third channel reached", rd_data, exp_reg[4]);

        fin = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule